// File: doc/BRIEF.md
# Power-Good Strap Latch and Power-Down Controller

This block sits beside a clock generator's output stage. At power-up it waits for the power-good pin to go high. It then captures two frequency/spread select straps once and decodes them into a frequency code and a spread code. After that capture the same pin changes meaning: it becomes a live, active-low power-down request. The straps are ignored from then on.

An analog front end turns each select strap into a three-level code (low, mid or high). The power-good pin and the four per-output enable inputs are asynchronous, so each passes through a two-flop synchronizer before the block uses it. The block also gates the four per-output enables into clock-enable outputs. Those outputs run only after capture, and only while power-down is not requested.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is held and just after it, `freq_code` and `spread_code` are 0, and `straps_valid`, `pd_req` and `clk_en` are all 0.
- R2: If `pg_pd_n` is high before a rising clock edge and stays high, `straps_valid` rises after the third rising edge from that point: two synchronizer stages plus the capture register. The codes take the decode of the straps present at that third edge.
- R3: Strap levels are encoded 2'b00 = low, 2'b01 = mid, 2'b1x = high. The frequency code is 0 = 100 MHz, 1 = 125 MHz, 2 = 200 MHz. The spread code is 0 = off, 1 = -0.5 %, 2 = +/-0.25 %, 3 = -0.75 %. When sel1 is low or high, `freq_code` is 0 and `spread_code` is {sel1 high, sel0 high}. When sel1 is mid, `spread_code` is 0 and `freq_code` is 2 if sel0 is high, otherwise 1.
- R4: Once `straps_valid` is 1 it stays 1 until reset. After that point, neither strap changes nor pulses on `pg_pd_n` alter `freq_code` or `spread_code`.
- R5: After capture, `pd_req` equals the inverse of `pg_pd_n`, delayed by two rising edges.
- R6: Before capture, `pd_req` stays 0 however long `pg_pd_n` is low.
- R7: `clk_en[i]` equals `oe_in[i]` delayed by two rising edges, but only while `straps_valid` is 1 and `pd_req` is 0. Otherwise it is 0.
- R8: A mid level on sel0 is treated as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pd_n | input | 1 | Power-good strobe; active-low power-down after capture |
| sel1_lvl | input | 2 | Three-level code of the high select strap |
| sel0_lvl | input | 2 | Three-level code of the low select strap |
| oe_in | input | 4 | Per-output enable requests, asynchronous |
| freq_code | output | 2 | Latched frequency selection |
| spread_code | output | 2 | Latched spread selection |
| straps_valid | output | 1 | High once the straps have been captured |
| pd_req | output | 1 | Power-down request |
| clk_en | output | 4 | Gated per-output clock enables |

## Verification
The capture and the power-down function share one pin, so they can fall in adjacent cycles. A pin that goes high and drops again soon after reaches the capture edge and then, two edges later, asserts power-down. The bench provokes this with random short high pulses on the pin, and it changes the straps and the enables in the same cycles. A per-edge reference model computes the codes, `pd_req` and `clk_en` for every cycle, and the bench judges each cycle against that model.

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl #(
  parameter int N_OUT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_pd_n,
  input  logic [1:0]       sel1_lvl,
  input  logic [1:0]       sel0_lvl,
  input  logic [N_OUT-1:0] oe_in,
  output logic [1:0]       freq_code,
  output logic [1:0]       spread_code,
  output logic             straps_valid,
  output logic             pd_req,
  output logic [N_OUT-1:0] clk_en
);

  logic [SYNC_STAGES-1:0] pg_sync;
  logic [N_OUT-1:0] oe_sync [SYNC_STAGES];
  logic pg_s;
  logic s1_hi, s1_mid, s0_hi;
  logic [1:0] dec_freq, dec_spread;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_sync <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) oe_sync[i] <= '0;
    end else begin
      pg_sync <= {pg_sync[SYNC_STAGES-2:0], pg_pd_n};
      oe_sync[0] <= oe_in;
      for (int i = 1; i < SYNC_STAGES; i++) oe_sync[i] <= oe_sync[i-1];
    end
  end

  assign pg_s   = pg_sync[SYNC_STAGES-1];
  assign s1_hi  = sel1_lvl[1];
  assign s1_mid = (sel1_lvl == 2'b01);
  assign s0_hi  = sel0_lvl[1];

  always_comb begin
    if (s1_mid) begin
      dec_freq   = s0_hi ? 2'd2 : 2'd1;
      dec_spread = 2'd0;
    end else begin
      dec_freq   = 2'd0;
      dec_spread = {s1_hi, s0_hi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      straps_valid <= 1'b0;
      freq_code    <= 2'd0;
      spread_code  <= 2'd0;
    end else if (!straps_valid && pg_s) begin
      straps_valid <= 1'b1;
      freq_code    <= dec_freq;
      spread_code  <= dec_spread;
    end
  end

  assign pd_req = straps_valid & ~pg_s;
  assign clk_en = (straps_valid && pg_s) ? oe_sync[SYNC_STAGES-1] : '0;

endmodule

module strap_latch_ctrl_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] oe_in,
  input logic [1:0]       freq_code,
  input logic [1:0]       spread_code,
  input logic             straps_valid,
  input logic             pd_req,
  input logic [N_OUT-1:0] clk_en
);
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> straps_valid);
  a_r4_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> ($stable(freq_code) && $stable(spread_code)));
  a_r3_freq_legal: assert property (@(posedge clk) disable iff (!rst_n)
    freq_code != 2'd3);
  a_r3_mid_no_spread: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code != 2'd0) |-> (spread_code == 2'd0));
  a_r6_no_pd_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |-> !pd_req);
  a_r7_pd_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> (clk_en == '0));
  a_r7_en_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en != '0) |-> ((clk_en & ~$past(oe_in, 2)) == '0));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .oe_in(oe_in), .freq_code(freq_code),
  .spread_code(spread_code), .straps_valid(straps_valid), .pd_req(pd_req),
  .clk_en(clk_en)
);

// File: tb/strap_latch_ctrl_tb_top.sv
module strap_latch_ctrl_tb_top;
  localparam time CYC = 20ns;

  logic clk = 0, rst_n = 0, pg_pd_n = 0;
  logic [1:0] sel1_lvl = 0, sel0_lvl = 0;
  logic [3:0] oe_in = 0;
  logic [1:0] freq_code, spread_code;
  logic straps_valid, pd_req;
  logic [3:0] clk_en;

  int tests = 0, fails = 0;
  logic m_valid, m_pg1, m_pg2;
  logic [1:0] m_freq, m_spread;
  logic [3:0] m_oe1, m_oe2;

  always #(CYC/2) clk = ~clk;

  strap_latch_ctrl dut_i (.*);

  function automatic logic [3:0] decode(input logic [1:0] s1, input logic [1:0] s0);
    logic hi0 = (s0 >= 2'b10);
    case (s1)
      2'b01:   return {hi0 ? 2'd2 : 2'd1, 2'd0};
      2'b00:   return {2'd0, 1'b0, hi0};
      default: return {2'd0, 1'b1, hi0};
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_pg1 = 0; m_pg2 = 0; m_freq = 0; m_spread = 0; m_oe1 = 0; m_oe2 = 0;
  endtask

  task automatic step();
    logic [3:0] d;
    @(posedge clk);
    if (rst_n) begin
      d = decode(sel1_lvl, sel0_lvl);
      if (!m_valid && m_pg2) begin
        m_valid = 1; m_freq = d[3:2]; m_spread = d[1:0];
      end
      m_pg2 = m_pg1; m_pg1 = pg_pd_n; m_oe2 = m_oe1; m_oe1 = oe_in;
    end
    @(negedge clk);
    check("R2 valid", {7'd0, straps_valid}, {7'd0, m_valid});
    check("R3 freq", {6'd0, freq_code}, {6'd0, m_freq});
    check("R3 spread", {6'd0, spread_code}, {6'd0, m_spread});
    check("R5 pd_req", {7'd0, pd_req}, {7'd0, m_valid & ~m_pg2});
    check("R7 clk_en", {4'd0, clk_en}, {4'd0, (m_valid && m_pg2) ? m_oe2 : 4'd0});
  endtask

  task automatic do_reset();
    rst_n = 0; pg_pd_n = 0; model_reset();
    repeat (2) @(negedge clk);
    check("R1 reset", {straps_valid, pd_req, clk_en, freq_code}, 8'd0);
    rst_n = 1;
  endtask

  task automatic capture(input logic [1:0] s1, input logic [1:0] s0,
                         input logic [1:0] ef, input logic [1:0] es);
    do_reset();
    sel1_lvl = s1; sel0_lvl = s0; oe_in = 4'hF;
    repeat (3) step();
    check("R6 no pd before capture", {7'd0, pd_req}, 8'd0);
    pg_pd_n = 1;
    repeat (4) step();
    check("R3 directed freq", {6'd0, freq_code}, {6'd0, ef});
    check("R3 directed spread", {6'd0, spread_code}, {6'd0, es});
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    capture(2'b00, 2'b00, 0, 0);
    capture(2'b00, 2'b10, 0, 1);
    capture(2'b10, 2'b00, 0, 2);
    capture(2'b11, 2'b10, 0, 3);
    capture(2'b01, 2'b00, 1, 0);
    capture(2'b01, 2'b11, 2, 0);
    capture(2'b01, 2'b01, 1, 0);
    capture(2'b00, 2'b01, 0, 0);
    check("R8 sel0 mid as low", {6'd0, spread_code}, 8'd0);
    sel1_lvl = 2'b10; sel0_lvl = 2'b10; pg_pd_n = 0;
    repeat (3) step();
    pg_pd_n = 1;
    repeat (3) step();
    check("R4 codes kept", {4'd0, freq_code, spread_code}, 8'd0);
    check("R4 valid kept", {7'd0, straps_valid}, 8'd1);
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      for (int c = 0; c < 80; c++) begin
        if ($urandom % 4 == 0) pg_pd_n = ~pg_pd_n;
        if ($urandom % 6 == 0) sel1_lvl = 2'($urandom);
        if ($urandom % 6 == 0) sel0_lvl = 2'($urandom);
        if ($urandom % 3 == 0) oe_in = 4'($urandom);
        step();
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule